// File: doc/BRIEF.md
# Sticky Event Interrupt Controller with Clear-on-Read Aliases

The block gathers single-cycle event pulses from four ports in several event classes and holds each one in a sticky bit until software clears it. A per-class mask selects which classes may pull the interrupt line low. The interrupt output is active-low and stands for an open-drain pad: 0 means the pad driver pulls the line low, 1 means the driver is released and the line floats to its external pull-up.

Software reaches the block through a simple register port: an address, a read strobe, a write strobe and write data. Each event class appears at two addresses. The even address is a plain view that changes nothing. The odd address returns the same value and clears that class as it is read. A command register offers a self-clearing global clear bit and a soft reset bit. The serial bus slave that produces the strobes sits outside the block.

Top module: `pse_irq_ctrl`

## Requirements
- R1: After reset every event bit and the mask are 0, `irq_n_o` is 1 and `rdata_o` is 0.
- R2: A one-cycle pulse on `evt_i` bit `c*NPORTS+p` sets event bit `p` of class `c` at that clock edge. The bit stays set until a clear removes it.
- R3: A read of address 0x00 returns one bit per class in bits [NCLASS-1:0]. Bit `c` is 1 when class `c` holds any pending event, whatever the mask says.
- R4: Address 0x01 is the read/write mask in bits [NCLASS-1:0]. `irq_n_o` is 0 exactly when some class with mask bit 1 has a pending event. It follows the register state in the cycle after the edge that changed that state.
- R5: A read of address 0x02+2c returns the class `c` events in bits [NPORTS-1:0]. It clears nothing, and `irq_n_o` keeps its level.
- R6: A read of address 0x03+2c returns the class `c` events and clears them at the same edge. The startup-fault class is class 3, and its clear-on-read address is 0x09.
- R7: An event pulse that arrives at the same edge as a clear of its class (clear-on-read, global clear or soft reset) is kept set after that edge.
- R8: Writing 1 to bit 7 of address 0x1A clears every event in every class and leaves the mask unchanged. The bit clears itself, and a read of 0x1A returns 0.
- R9: Writing 1 to bit 4 of address 0x1A clears every event and returns the mask to 0.
- R10: `rdata_o` is registered. It takes a new value one edge after `rd_i` and holds it until the next read. Unmapped addresses read 0. Writes to the status and event addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NCLASS*NPORTS | Event pulses; bit c*NPORTS+p belongs to class c, port p |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Open-drain interrupt, 0 = pull low, 1 = released |

## Verification
Each result has a fixed due cycle. An event pulse or a write shows on `irq_n_o` in the cycle right after the clock edge that captures it. Read data appears on `rdata_o` one edge after the read strobe, and a clear-on-read takes effect at that same edge. The bench drives every stimulus on a falling edge and samples on the following falling edge, so each check sits exactly one register stage after its cause. The same-edge cases of event against clear are driven together in a single cycle.

// File: rtl/pse_irq_pkg.sv
package pse_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_EVT0 = 8'h02;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 8'h1A;

  localparam int CMD_CLR_BIT  = 7;
  localparam int CMD_SRST_BIT = 4;

  // class c: plain view at even address, clear-on-read alias right above it
  function automatic logic [ADDR_W-1:0] evt_ro_addr(input int c);
    return ADDR_EVT0 + ADDR_W'(2 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] evt_cor_addr(input int c);
    return ADDR_EVT0 + ADDR_W'(2 * c + 1);
  endfunction
endpackage

// File: rtl/pse_irq_evt_bank.sv
module pse_irq_evt_bank #(
  parameter int NCLASS = 4,
  parameter int NPORTS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NCLASS-1:0][NPORTS-1:0]  set_i,
  input  logic [NCLASS-1:0]              clr_i,
  input  logic                           clr_all_i,
  output logic [NCLASS-1:0][NPORTS-1:0]  ev_o,
  output logic [NCLASS-1:0]              pend_o
);
  logic [NCLASS-1:0][NPORTS-1:0] ev_q;

  for (genvar c = 0; c < NCLASS; c++) begin : g_class
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  ev_q[c] <= '0;
      else if (clr_i[c] || clr_all_i) ev_q[c] <= set_i[c];  // new pulse survives clear
      else                          ev_q[c] <= ev_q[c] | set_i[c];
    end

    assign pend_o[c] = |ev_q[c];

    // R2: pending bits hold while no clear is applied
    a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[c] && !clr_all_i) |=> ((ev_q[c] & $past(ev_q[c])) == $past(ev_q[c])));

    // R7: a pulse is always captured, also against a clear
    a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[c] != '0) |=> ((ev_q[c] & $past(set_i[c])) == $past(set_i[c])));

    // R6: clear with no new pulse empties the class
    a_r6_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i[c] || clr_all_i) && set_i[c] == '0) |=> (ev_q[c] == '0));
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/pse_irq_regs.sv
module pse_irq_regs
  import pse_irq_pkg::*;
#(
  parameter int NCLASS = 4,
  parameter int NPORTS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_i,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NCLASS-1:0][NPORTS-1:0]  ev_i,
  input  logic [NCLASS-1:0]              pend_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NCLASS-1:0]              mask_o,
  output logic [NCLASS-1:0]              clr_o,
  output logic                           clr_all_o
);
  logic [NCLASS-1:0] ro_hit, cor_hit, mask_q;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic cmd_wr, glob_clr, soft_rst;

  for (genvar c = 0; c < NCLASS; c++) begin : g_dec
    assign ro_hit[c]  = (addr_i == evt_ro_addr(c));
    assign cor_hit[c] = (addr_i == evt_cor_addr(c));
    assign clr_o[c]   = rd_i && cor_hit[c];
  end

  assign cmd_wr    = wr_i && (addr_i == ADDR_CMD);
  assign glob_clr  = cmd_wr && wdata_i[CMD_CLR_BIT];
  assign soft_rst  = cmd_wr && wdata_i[CMD_SRST_BIT];
  assign clr_all_o = glob_clr || soft_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              mask_q <= '0;
    else if (soft_rst)                        mask_q <= '0;
    else if (wr_i && addr_i == ADDR_MASK)     mask_q <= wdata_i[NCLASS-1:0];
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == ADDR_STAT) rd_val[NCLASS-1:0] = pend_i;
    if (addr_i == ADDR_MASK) rd_val[NCLASS-1:0] = mask_q;
    for (int c = 0; c < NCLASS; c++)
      if (ro_hit[c] || cor_hit[c]) rd_val[NPORTS-1:0] = ev_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R8: command register never reads back set bits
  a_r8_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_CMD) |=> (rdata_o == '0));

  // R9: soft reset returns the mask to zero
  a_r9_mask_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (mask_o == '0));
endmodule

// File: rtl/pse_irq_out.sv
module pse_irq_out #(
  parameter int NCLASS = 4
) (
  input  logic [NCLASS-1:0] pend_i,
  input  logic [NCLASS-1:0] mask_i,
  output logic              irq_n_o
);
  // 0 = pad driver on (line pulled low), 1 = driver released
  assign irq_n_o = ~|(pend_i & mask_i);
endmodule

// File: rtl/pse_irq_ctrl.sv
module pse_irq_ctrl
  import pse_irq_pkg::*;
#(
  parameter int NCLASS = 4,
  parameter int NPORTS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCLASS*NPORTS-1:0]   evt_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       irq_n_o
);
  logic [NCLASS-1:0][NPORTS-1:0] set_w, ev_w;
  logic [NCLASS-1:0] pend_w, mask_w, clr_w;
  logic clr_all_w;

  for (genvar c = 0; c < NCLASS; c++) begin : g_unpack
    assign set_w[c] = evt_i[c*NPORTS +: NPORTS];
  end

  pse_irq_evt_bank #(.NCLASS(NCLASS), .NPORTS(NPORTS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_w),
    .clr_i     (clr_w),
    .clr_all_i (clr_all_w),
    .ev_o      (ev_w),
    .pend_o    (pend_w)
  );

  pse_irq_regs #(.NCLASS(NCLASS), .NPORTS(NPORTS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ev_i      (ev_w),
    .pend_i    (pend_w),
    .rdata_o   (rdata_o),
    .mask_o    (mask_w),
    .clr_o     (clr_w),
    .clr_all_o (clr_all_w)
  );

  pse_irq_out #(.NCLASS(NCLASS)) u_out (
    .pend_i  (pend_w),
    .mask_i  (mask_w),
    .irq_n_o (irq_n_o)
  );

  // R4: fully masked controller never pulls the line
  a_r4_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w == '0) |-> irq_n_o);

  // R4: nothing pending keeps the line released
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w == '0) |-> irq_n_o);
endmodule

// File: tb/tb_pse_irq_ctrl.sv
module tb_pse_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCLASS = 4;
  localparam int NPORTS = 4;
  localparam int NVEC = 20;

  localparam logic [1:0] OP_EV = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  // {op, addr, data, expected rdata (reads only), expected irq_n}
  localparam logic [34:0] VEC [NVEC] = '{
    {OP_EV, 8'h00, 16'h0800, 8'h00, 1'b1},  // R2 class2 port3, masked
    {OP_RD, 8'h00, 16'h0000, 8'h04, 1'b1},  // R3 status
    {OP_WR, 8'h01, 16'h000C, 8'h00, 1'b0},  // R4 unmask classes 2,3
    {OP_RD, 8'h01, 16'h0000, 8'h0C, 1'b0},  // R4 mask readback
    {OP_RD, 8'h06, 16'h0000, 8'h08, 1'b0},  // R5 plain view
    {OP_RD, 8'h06, 16'h0000, 8'h08, 1'b0},  // R5 still there
    {OP_RD, 8'h07, 16'h0000, 8'h08, 1'b1},  // R6 clear-on-read
    {OP_RD, 8'h06, 16'h0000, 8'h00, 1'b1},  // R6 cleared
    {OP_EV, 8'h00, 16'hA001, 8'h00, 1'b0},  // R2 class3 p1,p3 and class0 p0
    {OP_RD, 8'h00, 16'h0000, 8'h09, 1'b0},  // R3
    {OP_RD, 8'h09, 16'h0000, 8'h0A, 1'b1},  // R6 startup fault alias
    {OP_RD, 8'h02, 16'h0000, 8'h01, 1'b1},  // R5 class0 untouched
    {OP_WR, 8'h02, 16'h00FF, 8'h00, 1'b1},  // R10 write to event ignored
    {OP_RD, 8'h02, 16'h0000, 8'h01, 1'b1},  // R10
    {OP_WR, 8'h01, 16'h0001, 8'h00, 1'b0},  // R4 unmask class0
    {OP_WR, 8'h1A, 16'h0080, 8'h00, 1'b1},  // R8 global clear
    {OP_RD, 8'h02, 16'h0000, 8'h00, 1'b1},  // R8
    {OP_RD, 8'h1A, 16'h0000, 8'h00, 1'b1},  // R8 reads 0
    {OP_RD, 8'h01, 16'h0000, 8'h01, 1'b1},  // R8 mask kept
    {OP_RD, 8'h30, 16'h0000, 8'h00, 1'b1}   // R10 unmapped
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCLASS*NPORTS-1:0] evt = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic irq_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pse_irq_ctrl #(.NCLASS(NCLASS), .NPORTS(NPORTS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic step(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    case (op)
      OP_EV: evt = d;
      OP_WR: begin wr = 1'b1; addr = a; wdata = d[7:0]; end
      default: begin rd = 1'b1; addr = a; end
    endcase
    @(negedge clk);
    evt = '0; rd = 1'b0; wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", {7'b0, irq_n}, 8'h01);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata, 8'h00);
    step(OP_RD, 8'h01, 16'h0);
    chk("R1 mask after reset", rdata, 8'h00);
    step(OP_RD, 8'h00, 16'h0);
    chk("R1 status after reset", rdata, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][34:33], VEC[i][32:25], VEC[i][24:9]);
      if (VEC[i][34:33] == OP_RD)
        chk($sformatf("R3/R5/R6/R8/R10 vec %0d rdata", i), rdata, VEC[i][8:1]);
      chk($sformatf("R2/R4 vec %0d irq", i), {7'b0, irq_n}, {7'b0, VEC[i][0]});
    end

    // R10 hold across idle cycles
    step(OP_RD, 8'h01, 16'h0);
    repeat (4) @(negedge clk);
    chk("R10 rdata held", rdata, 8'h01);

    // R2 sticky over idle time
    step(OP_WR, 8'h01, 16'h000F);
    step(OP_EV, 8'h00, 16'h0010);
    repeat (5) @(negedge clk);
    step(OP_RD, 8'h04, 16'h0);
    chk("R2 sticky class1", rdata, 8'h01);
    chk("R2 irq low", {7'b0, irq_n}, 8'h00);

    // R7 event at the same edge as clear-on-read
    rd = 1'b1; addr = 8'h05; evt = 16'h0020;
    @(negedge clk);
    rd = 1'b0; evt = '0;
    chk("R7 cor returns old value", rdata, 8'h01);
    step(OP_RD, 8'h04, 16'h0);
    chk("R7 new event kept over cor", rdata, 8'h02);
    chk("R7 irq still low", {7'b0, irq_n}, 8'h00);

    // R7 event at the same edge as global clear
    wr = 1'b1; addr = 8'h1A; wdata = 8'h80; evt = 16'h0001;
    @(negedge clk);
    wr = 1'b0; evt = '0;
    step(OP_RD, 8'h02, 16'h0);
    chk("R7 new event kept over global clear", rdata, 8'h01);
    step(OP_RD, 8'h04, 16'h0);
    chk("R8 class1 cleared", rdata, 8'h00);

    // R9 soft reset
    step(OP_EV, 8'h00, 16'hF000);
    step(OP_WR, 8'h1A, 16'h0010);
    chk("R9 irq released", {7'b0, irq_n}, 8'h01);
    step(OP_RD, 8'h01, 16'h0);
    chk("R9 mask cleared", rdata, 8'h00);
    step(OP_RD, 8'h00, 16'h0);
    chk("R9 events cleared", rdata, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule